// File: doc/BRIEF.md
# USB host interrupt status register

This block holds the four low interrupt-status flags of an enhanced USB host controller: frame index wrap, root-port change, transaction error and transaction done. Each flag has its own hardware set rule. It watches the running frame index, the change lines of every root port together with that port's ownership flag, and a completion strobe that carries error, interrupt-on-complete and short-packet qualifiers.

Software clears a flag by writing a one to it. Writing a zero leaves the flag as it is. A single interrupt line is raised while any flag is set and its matching enable bit is on. The flags appear in the low nibble of a 32-bit read word, and the rest of that word reads as zero.

Top module: `usb_irq_status`

## Requirements
- R1: After reset all four flags are 0, `rd_data` is 0 and `irq` is 0, whatever the enables are.
- R2: A write (`wr_en`=1) clears each flag whose `wr_data` bit is 1 at the next clock edge. Flags whose `wr_data` bit is 0 keep their value. With no write and no event, a set flag stays set.
- R3: Flag 3 (`rd_data[3]`) sets when bit `ROLL_BIT` (default 13) of `frame_idx` differs from its value one cycle earlier. Rising and falling toggles both count. Changes to the other bits of `frame_idx` do not set it.
- R4: Flag 2 (`rd_data[2]`) sets on a 0-to-1 transition of any change line of a port whose owner flag is 0. Port p owns lines `port_chg[4p+k]`, where k=0 is connect change, k=1 is enable change, k=2 is over-current change and k=3 is forced resume. A line that stays high, or that falls, does not set the flag.
- R5: A rising change line of a port whose `port_owner` bit is 1 does not set flag 2.
- R6: Flag 1 (`rd_data[1]`) sets when `cmp_valid` and `cmp_err` are both 1.
- R7: Flag 0 (`rd_data[0]`) sets when `cmp_valid` is 1 and either `cmp_ioc` or `cmp_short` is 1.
- R8: A completion with both error and IOC sets flags 0 and 1 at the same edge. The qualifiers have no effect while `cmp_valid` is 0.
- R9: When a set event and a clearing write hit the same flag at the same edge, the flag ends up set.
- R10: `irq` is 1 exactly when some flag i is set and `irq_en[i]` is 1.
- R11: `rd_data[31:4]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_idx | input | FRAME_W (14) | Running frame index counter |
| port_chg | input | 4*NUM_PORTS (16) | Per-port change lines, four per port |
| port_owner | input | NUM_PORTS (4) | 1 = port handed to companion controller |
| cmp_valid | input | 1 | Transaction completion strobe |
| cmp_err | input | 1 | Completion ended in error |
| cmp_ioc | input | 1 | Descriptor requested interrupt on complete |
| cmp_short | input | 1 | Short packet received |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | 4 | Write-one-to-clear mask |
| irq_en | input | 4 | Per-flag interrupt enables |
| rd_data | output | 32 | Status read word |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a set event and a clearing write landing on the same flag in the same cycle. It only happens if the bench lines up a completion strobe with a full-mask write at one edge. The bench does exactly that, after first setting the other flags through their own events, so the one flag that must survive stands out. The port-change edge rule is also subtle: a line that is held high across a clear must not set the flag again. So the bench keeps each change line high through a clearing write and then lowers it, checking the flag after each step. It does this for every port, every line and both ownership values.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    localparam int STAT_W  = 4;
    localparam int CHG_PER_PORT = 4;
    localparam int READ_W  = 32;

    typedef struct packed {
        logic roll;   // bit 3
        logic port;   // bit 2
        logic err;    // bit 1
        logic done;   // bit 0
    } irq_stat_t;
endpackage

// File: rtl/usb_irq_roll_det.sv
module usb_irq_roll_det #(
    parameter int FRAME_W  = 14,
    parameter int ROLL_BIT = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] frame_idx,
    output logic               roll_evt
);
    logic bit_d, bit_q;
    logic unused_frame_bits;

    assign unused_frame_bits = ^frame_idx;

    always_comb begin
        bit_d    = frame_idx[ROLL_BIT];
        roll_evt = frame_idx[ROLL_BIT] ^ bit_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
    end
endmodule

// File: rtl/usb_irq_port_agg.sv
module usb_irq_port_agg #(
    parameter int NUM_PORTS = 4,
    parameter int CHG_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS*CHG_W-1:0] port_chg,
    input  logic [NUM_PORTS-1:0]       port_owner,
    output logic                       port_evt
);
    localparam int LINES = NUM_PORTS * CHG_W;

    logic [LINES-1:0]     prev_d, prev_q;
    logic [LINES-1:0]     rise;
    logic [NUM_PORTS-1:0] port_hit;

    always_comb begin
        prev_d = port_chg;
        rise   = port_chg & ~prev_q;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign port_hit[p] = (|rise[p*CHG_W +: CHG_W]) & ~port_owner[p];
    end

    assign port_evt = |port_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assert_owned_ports_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (&port_owner) |-> !port_evt);
endmodule

// File: rtl/usb_irq_stat_reg.sv
module usb_irq_stat_reg
    import usb_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  irq_stat_t         set_vec,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output irq_stat_t         stat_q
);
    irq_stat_t         stat_d;
    logic [STAT_W-1:0] clr;

    always_comb begin
        clr    = wr_en ? wr_data : '0;
        stat_d = (stat_q & ~clr) | set_vec;   // set has priority
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    for (genvar i = 0; i < STAT_W; i++) begin : g_chk
        assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> stat_q[i]);
        assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[i] && !set_vec[i]) |=> !stat_q[i]);
        assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[i] && !(wr_en && wr_data[i])) |=> stat_q[i]);
    end
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
    import usb_irq_pkg::*;
#(
    parameter int FRAME_W   = 14,
    parameter int ROLL_BIT  = 13,
    parameter int NUM_PORTS = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [FRAME_W-1:0]                frame_idx,
    input  logic [NUM_PORTS*CHG_PER_PORT-1:0] port_chg,
    input  logic [NUM_PORTS-1:0]              port_owner,
    input  logic                              cmp_valid,
    input  logic                              cmp_err,
    input  logic                              cmp_ioc,
    input  logic                              cmp_short,
    input  logic                              wr_en,
    input  logic [STAT_W-1:0]                 wr_data,
    input  logic [STAT_W-1:0]                 irq_en,
    output logic [READ_W-1:0]                 rd_data,
    output logic                              irq
);
    logic      roll_evt, port_evt;
    irq_stat_t set_vec, stat_q;

    usb_irq_roll_det #(.FRAME_W(FRAME_W), .ROLL_BIT(ROLL_BIT)) u_roll (
        .clk(clk), .rst_n(rst_n), .frame_idx(frame_idx), .roll_evt(roll_evt)
    );

    usb_irq_port_agg #(.NUM_PORTS(NUM_PORTS), .CHG_W(CHG_PER_PORT)) u_port (
        .clk(clk), .rst_n(rst_n), .port_chg(port_chg),
        .port_owner(port_owner), .port_evt(port_evt)
    );

    always_comb begin
        set_vec.roll = roll_evt;
        set_vec.port = port_evt;
        set_vec.err  = cmp_valid & cmp_err;
        set_vec.done = cmp_valid & (cmp_ioc | cmp_short);
    end

    usb_irq_stat_reg u_stat (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .wr_en(wr_en), .wr_data(wr_data), .stat_q(stat_q)
    );

    always_comb begin
        rd_data = '0;
        rd_data[STAT_W-1:0] = stat_q;
        irq = |(stat_q & irq_en);
    end

    assert_dual_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_err && cmp_ioc) |=> (rd_data[1:0] == 2'b11));
    assert_roll_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        roll_evt |=> rd_data[3]);
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);
endmodule

// File: tb/usb_irq_status_tb.sv
module usb_irq_status_tb;
    localparam int CLK_P = 10;

    logic        clk = 0, rst_n = 0;
    logic [13:0] frame_idx = '0;
    logic [15:0] port_chg = '0;
    logic [3:0]  port_owner = '0;
    logic        cmp_valid = 0, cmp_err = 0, cmp_ioc = 0, cmp_short = 0;
    logic        wr_en = 0;
    logic [3:0]  wr_data = '0, irq_en = '0;
    logic [31:0] rd_data;
    logic        irq;
    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    usb_irq_status u_dut (
        .clk(clk), .rst_n(rst_n), .frame_idx(frame_idx), .port_chg(port_chg),
        .port_owner(port_owner), .cmp_valid(cmp_valid), .cmp_err(cmp_err),
        .cmp_ioc(cmp_ioc), .cmp_short(cmp_short), .wr_en(wr_en),
        .wr_data(wr_data), .irq_en(irq_en), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // inputs are changed at negedge; one posedge applies them, check at next negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        wr_en = 1; wr_data = 4'hF;
        step();
        wr_en = 0; wr_data = '0;
    endtask

    task automatic make_status(logic [3:0] s);
        clear_all();
        cmp_valid = s[0] | s[1]; cmp_ioc = s[0]; cmp_err = s[1];
        port_chg[0] = s[2];
        if (s[3]) frame_idx[13] = ~frame_idx[13];
        step();
        cmp_valid = 0; cmp_ioc = 0; cmp_err = 0; port_chg[0] = 0;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        irq_en = 4'hF;
        repeat (3) @(negedge clk);
        check("R1 rd during reset", rd_data, 32'h0);
        rst_n = 1;
        step();
        check("R1 rd after reset", rd_data, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R6 R7 R8: all completion qualifier combinations
        for (int v = 0; v < 16; v++) begin
            logic [3:0] c = v[3:0];
            logic [31:0] e;
            e = 32'h0;
            e[0] = c[3] & (c[1] | c[0]);
            e[1] = c[3] & c[2];
            cmp_valid = c[3]; cmp_err = c[2]; cmp_ioc = c[1]; cmp_short = c[0];
            step();
            cmp_valid = 0; cmp_err = 0; cmp_ioc = 0; cmp_short = 0;
            check("R6 R7 R8 completion decode", rd_data, e);
            clear_all();
        end

        // R2: selective write-one-to-clear and hold
        cmp_valid = 1; cmp_err = 1; cmp_ioc = 1;
        step();
        cmp_valid = 0; cmp_err = 0; cmp_ioc = 0;
        wr_en = 1; wr_data = 4'b0001;
        step();
        check("R2 clear bit0 only", rd_data, 32'h2);
        wr_data = 4'b0000;
        step();
        wr_en = 0;
        check("R2 write zero no effect", rd_data, 32'h2);
        repeat (5) step();
        check("R2 sticky hold", rd_data, 32'h2);
        clear_all();
        check("R2 full clear", rd_data, 32'h0);

        // R3: rollover bit toggles, low bits ignored
        frame_idx = 14'h2000;
        step();
        check("R3 rising toggle", rd_data, 32'h8);
        clear_all();
        frame_idx = 14'h3FFF;
        step();
        check("R3 low bits ignored", rd_data, 32'h0);
        frame_idx = 14'h0000;
        step();
        check("R3 falling toggle", rd_data, 32'h8);
        clear_all();

        // R4 R5: each port, each line, both owner values
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 4; k++) begin
                for (int o = 0; o < 2; o++) begin
                    port_owner = '0;
                    port_owner[p] = o[0];
                    port_chg[p*4+k] = 1;
                    step();
                    check(o ? "R5 owned port ignored" : "R4 rising change",
                          rd_data, o ? 32'h0 : 32'h4);
                    clear_all();
                    check("R4 held line no reset", rd_data, 32'h0);
                    port_chg[p*4+k] = 0;
                    step();
                    check("R4 falling line no set", rd_data, 32'h0);
                end
            end
        end
        port_owner = '0;

        // R9: set and clear collide
        make_status(4'b1101);
        wr_en = 1; wr_data = 4'hF; cmp_valid = 1; cmp_err = 1;
        step();
        wr_en = 0; wr_data = 0; cmp_valid = 0; cmp_err = 0;
        check("R9 set beats clear", rd_data, 32'h2);

        // R10 R11: every status pattern against every enable
        for (int s = 0; s < 16; s++) begin
            make_status(s[3:0]);
            check("R11 status layout", rd_data, {28'h0, s[3:0]});
            for (int e = 0; e < 16; e++) begin
                irq_en = e[3:0];
                #1;
                check("R10 irq gating", {31'b0, irq},
                      {31'b0, ((s[3:0] & e[3:0]) != 0)});
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule